// File: doc/BRIEF.md
# GPIO Bank with Sleep-State Control

A 32-pin general-purpose I/O bank controlled through registers. Software sets the pin direction, drives output levels with write-one-to-set and write-one-to-clear masks, and gives each pin a 2-bit function code. Code 0 makes the pin ordinary GPIO. Codes 1 to 3 hand the pin's output value to one of three peripheral data inputs. The pad level of every pin is read back through a two-flop synchronizer, whatever the pin's direction. The same synchronized value goes to the peripherals on `pin_level`.

The bank also controls low-power state. A separate register holds the level each pin must drive while asleep. While `sleep_req` is high, every output pin drives that level in the same cycle, and the run-time output register keeps its contents. When the pins wake, they return to their run-time values at once. After reset and after any sleep, input receivers stay disabled, and the level readback returns zero, until software writes a 1 to the release flag.

There are two register write lanes, so a set and a clear can reach the same bit in the same cycle. Reads are combinational on a separate read address.

Top module: `gpio_sleep_bank`

Address map (3-bit): 0 level (read-only), 1 direction, 2 set (reads back the output register), 3 clear (reads 0), 4 function codes pins 0–15, 5 function codes pins 16–31, 6 sleep levels, 7 control (bit 0: receiver hold).

## Requirements
- R1: Reset values:
  - the direction register reads `INV_DIR_MASK` (default 32'hF000_0000), so every pin is an input and `pad_oe` is 0;
  - the output, function-code and sleep registers read 0;
  - the receiver hold is set: `rx_enable` is 0 and address 7 reads 1.
- R2: `pad_oe[i]` equals direction bit i XOR `INV_DIR_MASK[i]`. By default pins 28–31 have inverted sense: a 1 makes the pin an input.
- R3: Writing address 2 ORs the written ones into the output register. Writing address 3 clears the written ones. Zero bits leave a pin unchanged. Address 2 reads back the output register.
- R4: If one lane sets a bit and the other clears it in the same cycle, the bit ends up 0. If both lanes write the same other register in the same cycle, lane b's data is stored.
- R5: Pin i takes its code from address 4 bits [2i+1:2i] for i<16, and from address 5 bits [2(i-16)+1:2(i-16)] for i≥16. The pin drives:
  - for code 0, its output register bit;
  - for code 1, `alt1_dout[i]`;
  - for code 2, `alt2_dout[i]`;
  - for code 3, `alt3_dout[i]`.
- R6: With the hold released, `pin_level` and address 0 show `pad_in` two clock edges after it changes, for every pin whatever its direction. Writes to address 0 have no effect.
- R7: While `sleep_req` is high, each pin with `pad_oe` set drives its address-6 bit on `pad_out` in the same cycle. `pad_oe` is unchanged.
- R8: When `sleep_req` falls, `pad_out` returns at once to the run-time value. The output register keeps its pre-sleep contents.
- R9: The receiver hold is set at reset and in every cycle `sleep_req` is high, and it stays set after wake. While it is set, `rx_enable` is 0 and `pin_level` is 0. Writing 1 to address 7 bit 0 clears the hold at the next edge, unless `sleep_req` is high. Writing 0 has no effect.
- R10: Address 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_we | input | 1 | Lane a write enable |
| a_addr | input | 3 | Lane a register address |
| a_wdata | input | 32 | Lane a write data |
| b_we | input | 1 | Lane b write enable |
| b_addr | input | 3 | Lane b register address |
| b_wdata | input | 32 | Lane b write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| sleep_req | input | 1 | Low-power request |
| pad_in | input | 32 | Pad levels |
| pad_oe | output | 32 | Pad output enables |
| pad_out | output | 32 | Pad output values |
| rx_enable | output | 1 | Input receivers enabled |
| alt1_dout | input | 32 | Function 1 peripheral data |
| alt2_dout | input | 32 | Function 2 peripheral data |
| alt3_dout | input | 32 | Function 3 peripheral data |
| pin_level | output | 32 | Synchronized pad levels to peripherals |

## Verification
A wrong output register or wrong function code shows on `pad_out` in the cycle after the write that caused it. A wrong sleep mux shows combinationally in the same cycle as `sleep_req`. A hold flag stuck at the wrong value shows on `rx_enable` at once. It also shows on `pin_level` two edges later, as a zero where data was expected or as data where zero was expected. The wrong-hold case is checked both straight after wake and after an attempted release during sleep.

// File: rtl/gpio_sleep_bank.sv
module gpio_sleep_bank #(
  parameter logic [31:0] INV_DIR_MASK = 32'hF000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_we,
  input  logic [2:0]  a_addr,
  input  logic [31:0] a_wdata,
  input  logic        b_we,
  input  logic [2:0]  b_addr,
  input  logic [31:0] b_wdata,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        sleep_req,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_oe,
  output logic [31:0] pad_out,
  output logic        rx_enable,
  input  logic [31:0] alt1_dout,
  input  logic [31:0] alt2_dout,
  input  logic [31:0] alt3_dout,
  output logic [31:0] pin_level
);
  localparam int W    = 32;
  localparam int HALF = W / 2;

  localparam logic [2:0] ADR_LEVEL = 3'd0;
  localparam logic [2:0] ADR_DIR   = 3'd1;
  localparam logic [2:0] ADR_SET   = 3'd2;
  localparam logic [2:0] ADR_CLR   = 3'd3;
  localparam logic [2:0] ADR_FLO   = 3'd4;
  localparam logic [2:0] ADR_FHI   = 3'd5;
  localparam logic [2:0] ADR_SLP   = 3'd6;
  localparam logic [2:0] ADR_CTL   = 3'd7;

  logic [W-1:0] dir_q, out_q, flo_q, fhi_q, slp_q, s1_q, s2_q;
  logic         hold_q;
  logic [7:0]   a_hit, b_hit;
  logic [W-1:0] set_m, clr_m, run_out;
  logic         release_w;

  function automatic logic [W-1:0] merge(input logic ah, input logic bh,
                                         input logic [W-1:0] ad, input logic [W-1:0] bd,
                                         input logic [W-1:0] cur);
    return bh ? bd : (ah ? ad : cur);
  endfunction

  assign a_hit     = a_we ? (8'b1 << a_addr) : 8'b0;
  assign b_hit     = b_we ? (8'b1 << b_addr) : 8'b0;
  assign set_m     = ({W{a_hit[ADR_SET]}} & a_wdata) | ({W{b_hit[ADR_SET]}} & b_wdata);
  assign clr_m     = ({W{a_hit[ADR_CLR]}} & a_wdata) | ({W{b_hit[ADR_CLR]}} & b_wdata);
  assign release_w = (a_hit[ADR_CTL] & a_wdata[0]) | (b_hit[ADR_CTL] & b_wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= INV_DIR_MASK;
      out_q  <= '0;
      flo_q  <= '0;
      fhi_q  <= '0;
      slp_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      hold_q <= 1'b1;
    end else begin
      dir_q  <= merge(a_hit[ADR_DIR], b_hit[ADR_DIR], a_wdata, b_wdata, dir_q);
      flo_q  <= merge(a_hit[ADR_FLO], b_hit[ADR_FLO], a_wdata, b_wdata, flo_q);
      fhi_q  <= merge(a_hit[ADR_FHI], b_hit[ADR_FHI], a_wdata, b_wdata, fhi_q);
      slp_q  <= merge(a_hit[ADR_SLP], b_hit[ADR_SLP], a_wdata, b_wdata, slp_q);
      out_q  <= (out_q | set_m) & ~clr_m;
      s1_q   <= pad_in & ~{W{hold_q}};
      s2_q   <= s1_q;
      if (sleep_req)      hold_q <= 1'b1;
      else if (release_w) hold_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] code;
    if (i < HALF) begin : g_lo
      assign code = flo_q[2*i +: 2];
    end else begin : g_hi
      assign code = fhi_q[2*(i-HALF) +: 2];
    end
    assign run_out[i] = (code == 2'd0) ? out_q[i]     :
                        (code == 2'd1) ? alt1_dout[i] :
                        (code == 2'd2) ? alt2_dout[i] : alt3_dout[i];
  end

  assign pad_oe    = dir_q ^ INV_DIR_MASK;
  assign pad_out   = sleep_req ? slp_q : run_out;
  assign rx_enable = ~hold_q;
  assign pin_level = s2_q;

  always_comb begin
    case (rd_addr)
      ADR_LEVEL: rd_data = s2_q;
      ADR_DIR:   rd_data = dir_q;
      ADR_SET:   rd_data = out_q;
      ADR_CLR:   rd_data = '0;
      ADR_FLO:   rd_data = flo_q;
      ADR_FHI:   rd_data = fhi_q;
      ADR_SLP:   rd_data = slp_q;
      default:   rd_data = {{(W-1){1'b0}}, hold_q};
    endcase
  end
endmodule

module gpio_sleep_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sleep_req,
  input logic        rx_enable,
  input logic [31:0] pad_oe,
  input logic [31:0] pad_out,
  input logic [31:0] pin_level,
  input logic [31:0] slp_q,
  input logic [31:0] out_q,
  input logic [31:0] set_m,
  input logic [31:0] clr_m
);
  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_m & clr_m)) |=> ((out_q & $past(set_m & clr_m)) == 32'h0));

  assert_sleep_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (((pad_out ^ slp_q) & pad_oe) == 32'h0));

  assert_wake_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_req) |-> !rx_enable);

  assert_hold_gates_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> ##2 (pin_level == 32'h0));
endmodule

bind gpio_sleep_bank gpio_sleep_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .rx_enable(rx_enable),
  .pad_oe(pad_oe), .pad_out(pad_out), .pin_level(pin_level),
  .slp_q(slp_q), .out_q(out_q), .set_m(set_m), .clr_m(clr_m)
);

// File: tb/gpio_sleep_bank_tb.sv
module gpio_sleep_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_we = 1'b0, b_we = 1'b0;
  logic [2:0]  a_addr = '0, b_addr = '0, rd_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] rd_data;
  logic        sleep_req = 1'b0;
  logic [31:0] pad_in = 32'hDEAD_BEEF;
  logic [31:0] pad_oe, pad_out, pin_level;
  logic        rx_enable;
  logic [31:0] alt1_dout = '0, alt2_dout = 32'hFFFF_FFFF, alt3_dout = 32'h0001_0000;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  gpio_sleep_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sleep_req(sleep_req), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .rx_enable(rx_enable),
    .alt1_dout(alt1_dout), .alt2_dout(alt2_dout), .alt3_dout(alt3_dout),
    .pin_level(pin_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {write addr, write data, read addr, expected read}
  localparam logic [69:0] VEC [10] = '{
    {3'd1, 32'h0000_00FF, 3'd1, 32'h0000_00FF},
    {3'd2, 32'h0000_0F0F, 3'd2, 32'h0000_0F0F},
    {3'd3, 32'h0000_0003, 3'd2, 32'h0000_0F0C},
    {3'd2, 32'h0000_0000, 3'd2, 32'h0000_0F0C},
    {3'd4, 32'h0000_A5A5, 3'd4, 32'h0000_A5A5},
    {3'd5, 32'h0000_1234, 3'd5, 32'h0000_1234},
    {3'd6, 32'hFFFF_0000, 3'd6, 32'hFFFF_0000},
    {3'd3, 32'hFFFF_FFFF, 3'd3, 32'h0000_0000},
    {3'd0, 32'hFFFF_FFFF, 3'd2, 32'h0000_0000},
    {3'd0, 32'hFFFF_FFFF, 3'd0, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk);
    a_we = 1'b1; a_addr = ad; a_wdata = d;
    @(negedge clk);
    a_we = 1'b0;
  endtask

  task automatic wr2(input logic [2:0] aa, input logic [31:0] ad,
                     input logic [2:0] ba, input logic [31:0] bd);
    @(negedge clk);
    a_we = 1'b1; a_addr = aa; a_wdata = ad;
    b_we = 1'b1; b_addr = ba; b_wdata = bd;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] ad, input logic [31:0] exp, input string tag);
    rd_addr = ad;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
    end
  end

  initial begin
    logic [31:0] run_val;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_chk(3'd1, 32'hF000_0000, "R1 dir reset");
    chk("R1 pad_oe reset", pad_oe, 32'h0);
    rd_chk(3'd2, 32'h0, "R1 out reset");
    rd_chk(3'd4, 32'h0, "R1 func lo reset");
    rd_chk(3'd5, 32'h0, "R1 func hi reset");
    rd_chk(3'd6, 32'h0, "R1 sleep reset");
    rd_chk(3'd7, 32'h1, "R1 hold reset");
    chk("R9 rx_enable after reset", {31'h0, rx_enable}, 32'h0);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][69:67], VEC[i][66:35]);
      rd_chk(VEC[i][34:32], VEC[i][31:0],
             $sformatf("table row %0d (R2 R3 R5 R6 R7 R10)", i));
    end

    wr(3'd1, 32'h0001_00FF);
    #1 chk("R2 oe with inverted top pins", pad_oe, 32'hF001_00FF);
    wr(3'd1, 32'h1001_00FF);
    #1 chk("R2 inverted pin28 to input", pad_oe, 32'hE001_00FF);

    wr(3'd4, 32'h0000_E400);
    wr(3'd5, 32'h0000_0003);
    wr(3'd2, 32'h0000_00F0);
    #1;
    chk("R5 codes 0..3 on pins 4..7", {28'h0, pad_out[7:4]}, 32'h5);
    chk("R5 upper reg pin16 code3", {31'h0, pad_out[16]}, 32'h1);
    chk("R5 gpio pins 0..3", {28'h0, pad_out[3:0]}, 32'h0);

    wr2(3'd2, 32'h0000_0003, 3'd3, 32'h0000_0001);
    rd_chk(3'd2, 32'h0000_00F2, "R4 clear wins same cycle");
    wr2(3'd6, 32'h0000_1111, 3'd6, 32'h0000_2222);
    rd_chk(3'd6, 32'h0000_2222, "R4 lane b wins");

    wr(3'd7, 32'h0);
    rd_chk(3'd7, 32'h1, "R9 write 0 keeps hold");
    wr(3'd7, 32'h1);
    chk("R9 release", {31'h0, rx_enable}, 32'h1);
    rd_chk(3'd7, 32'h0, "R9 hold flag cleared");

    repeat (2) @(negedge clk);
    rd_chk(3'd0, 32'hDEAD_BEEF, "R6 level after release");
    pad_in = 32'h1234_5678;
    @(negedge clk);
    chk("R6 one edge old value", pin_level, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R6 two edges new value", pin_level, 32'h1234_5678);
    rd_chk(3'd0, 32'h1234_5678, "R6 level readback");

    #1 run_val = pad_out;
    @(negedge clk);
    sleep_req = 1'b1;
    #1;
    chk("R7 sleep level same cycle", pad_out & pad_oe, 32'h0000_2222 & 32'hE001_00FF);
    chk("R7 oe unchanged in sleep", pad_oe, 32'hE001_00FF);
    @(negedge clk);
    chk("R9 hold during sleep", {31'h0, rx_enable}, 32'h0);
    wr(3'd7, 32'h1);
    chk("R9 sleep overrides release", {31'h0, rx_enable}, 32'h0);
    sleep_req = 1'b0;
    #1;
    chk("R8 run value restored", pad_out, run_val);
    rd_chk(3'd2, 32'h0000_00F2, "R8 output reg kept");
    repeat (2) @(negedge clk);
    chk("R9 hold after wake", {31'h0, rx_enable}, 32'h0);
    chk("R9 level gated after wake", pin_level, 32'h0);
    wr(3'd7, 32'h1);
    chk("R9 release after wake", {31'h0, rx_enable}, 32'h1);
    repeat (2) @(negedge clk);
    chk("R6 level back after release", pin_level, 32'h1234_5678);

    done = 1'b1;
    finish_up();
  end
endmodule